// File: doc/BRIEF.md
# Branch Target Cache

This block is a fetch-side predictor for simple branches. It is a direct-mapped table. Each entry remembers the full address of a branch instruction and the address that branch jumped to. The fetch unit presents one instruction address per cycle. When that address hits a live entry, the block raises `pred_hit` and drives the stored target on `pred_tgt` in the same cycle. The fetch unit then takes that target as its next address, and the instruction travels on marked as predicted-taken. An instruction that does not hit travels on unmarked.

The execute stage reports every resolved simple branch through the update port, whether the branch was taken or not. A taken outcome writes the entry as live. A not-taken outcome writes the entry as dead.

The table read is registered and runs ahead of the fetch stream. In each accepted fetch cycle, the entry two words beyond the current address is read, and the result is held in a short lookahead pipe until fetch reaches that address. Any restart of the stream empties the pipe. A restart is either an external redirect or one of the block's own hits. For that reason the first two sequential fetches after a restart are never predicted.

Top module: `brtgt_cache`

## Requirements
- R1: After reset every entry is dead, and `pred_hit` stays 0 until a taken update has been written and then fetched.
- R2: A taken update for address P with target T makes a later fetch of P hit, provided P is at least the third accepted sequential fetch since the last restart. In that cycle `pred_hit` is 1 and `pred_tgt` equals T.
- R3: A not-taken update for address P kills the entry, so later fetches of P do not hit.
- R4: The entry index is fetch address bits 11 down to 2. A newer update whose address has the same index replaces the older entry, and the older address no longer hits.
- R5: A hit needs the stored branch address to equal the whole fetch address. A fetch of another address with the same index does not hit.
- R6: After a redirect, or after a hit, the first and second accepted fetches never hit. The third can hit.
- R7: In a cycle with `redirect` high, `pred_hit` is 0 even when `fetch_addr` would match. That cycle's fetch is discarded, and the next address starts a new stream.
- R8: In a cycle with `fetch_vld` low, `pred_hit` is 0 and the lookahead holds its state. The sequence then continues when fetch resumes.
- R9: If an update and the lookahead read reach the same index in the same cycle, the read returns the contents from before the update.
- R10: The update port has no back-pressure. It has no ready signal, and one packet is written on every cycle `upd_vld` is high. Back-to-back packets all take effect.
- R11: `pred_tgt` is 0 whenever `pred_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_vld | input | 1 | The address on `fetch_addr` is consumed this cycle; the next address follows sequentially unless a restart happens |
| fetch_addr | input | 32 | Byte address of the instruction being fetched |
| redirect | input | 1 | Restart from outside; this cycle's fetch is discarded |
| upd_vld | input | 1 | Update packet present, always accepted |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_tgt | input | 32 | Target of the resolved branch |
| upd_taken | input | 1 | 1 if the branch was taken (entry live), 0 if not (entry dead) |
| pred_hit | output | 1 | The current fetch is predicted taken |
| pred_tgt | output | 32 | Predicted next fetch address, 0 without a hit |

## Verification
The assertions check four rules on every cycle. There is no hit within the first two fetches after a redirect or a hit. There is no hit in a redirect cycle or a stalled cycle. There are never two hits in a row. And there is no hit before any taken update has arrived. Only the bench's scenarios can show which target comes out. The same goes for aliasing addresses being rejected or replacing each other, a not-taken outcome killing an entry, and the order of a same-cycle write and read.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  parameter int unsigned AW = 32;

  typedef logic [AW-1:0] addr_t;

  // stored pair: branch address and where it went
  typedef struct packed {
    addr_t src;
    addr_t dst;
  } pair_t;

  // lookahead slot: ok = read issued inside the current stream
  typedef struct packed {
    logic  ok;
    logic  live;
    pair_t pair;
  } slot_t;
endpackage

// File: rtl/brtgt_store.sv
module brtgt_store
  import brtgt_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_live,
  output pair_t            rd_pair,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_live,
  input  pair_t            wr_pair
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] live_q;
  pair_t            mem_q [DEPTH];

  // live bits carry reset; the pair array does not need it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      rd_live <= 1'b0;
    end else begin
      if (rd_en) rd_live <= live_q[rd_idx];
      if (wr_en) live_q[wr_idx] <= wr_live;
    end
  end

  // nonblocking: a read to the index being written sees old contents
  always_ff @(posedge clk) begin
    if (rd_en) rd_pair <= mem_q[rd_idx];
    if (wr_en) mem_q[wr_idx] <= wr_pair;
  end
endmodule

// File: rtl/brtgt_pipe.sv
module brtgt_pipe
  import brtgt_pkg::*;
#(
  parameter int unsigned LOOK = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  flush,
  input  logic  head_live,
  input  pair_t head_pair,
  output slot_t tail
);
  logic  ok_head_q;
  slot_t head_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ok_head_q <= 1'b0;
    else if (flush) ok_head_q <= 1'b0;
    else if (adv)   ok_head_q <= 1'b1;
  end

  assign head_s = '{ok: ok_head_q, live: head_live, pair: head_pair};

  generate
    if (LOOK == 1) begin : g_direct
      assign tail = head_s;
    end else begin : g_chain
      slot_t chain_q [LOOK-1];
      for (genvar i = 0; i < LOOK - 1; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     chain_q[i] <= '0;
          else if (flush) chain_q[i] <= '0;
          else if (adv) begin
            if (i == 0) chain_q[i] <= head_s;
            else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
          end
        end
      end
      assign tail = chain_q[LOOK-2];
    end
  endgenerate
endmodule

// File: rtl/brtgt_match.sv
module brtgt_match
  import brtgt_pkg::*;
(
  input  logic  fetch_vld,
  input  logic  redirect,
  input  addr_t fetch_addr,
  input  slot_t slot,
  output logic  hit,
  output addr_t tgt
);
  logic same;

  assign same = (slot.pair.src == fetch_addr);
  assign hit  = fetch_vld & ~redirect & slot.ok & slot.live & same;
  assign tgt  = hit ? slot.pair.dst : '0;
endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache
  import brtgt_pkg::*;
#(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned IDX_LSB = 2,
  parameter int unsigned LOOK    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic          redirect,
  input  logic          upd_vld,
  input  logic [AW-1:0] upd_pc,
  input  logic [AW-1:0] upd_tgt,
  input  logic          upd_taken,
  output logic          pred_hit,
  output logic [AW-1:0] pred_tgt
);
  localparam logic [IDX_W-1:0] AHEAD = IDX_W'(LOOK);

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             rd_live, flush;
  pair_t            rd_pair, wr_pair;
  slot_t            tail;

  // carries above the index field do not change the index
  assign rd_idx  = fetch_addr[IDX_LSB +: IDX_W] + AHEAD;
  assign wr_idx  = upd_pc[IDX_LSB +: IDX_W];
  assign wr_pair = '{src: upd_pc, dst: upd_tgt};
  assign flush   = redirect | pred_hit;

  brtgt_store #(.IDX_W(IDX_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (fetch_vld),
    .rd_idx  (rd_idx),
    .rd_live (rd_live),
    .rd_pair (rd_pair),
    .wr_en   (upd_vld),
    .wr_idx  (wr_idx),
    .wr_live (upd_taken),
    .wr_pair (wr_pair)
  );

  brtgt_pipe #(.LOOK(LOOK)) pipe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (fetch_vld),
    .flush     (flush),
    .head_live (rd_live),
    .head_pair (rd_pair),
    .tail      (tail)
  );

  brtgt_match match_i (
    .fetch_vld  (fetch_vld),
    .redirect   (redirect),
    .fetch_addr (fetch_addr),
    .slot       (tail),
    .hit        (pred_hit),
    .tgt        (pred_tgt)
  );
endmodule

// File: rtl/brtgt_cache_chk.sv
module brtgt_cache_chk #(
  parameter int unsigned LOOK = 2
) (
  input logic clk,
  input logic rst_n,
  input logic fetch_vld,
  input logic redirect,
  input logic upd_vld,
  input logic upd_taken,
  input logic pred_hit
);
  localparam logic [7:0] LOOK_C = 8'(LOOK);

  logic [7:0] run_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (redirect || pred_hit)              run_q <= '0;
      else if (fetch_vld && run_q < LOOK_C)  run_q <= run_q + 8'd1;
      if (upd_vld && upd_taken) seen_q <= 1'b1;
    end
  end

  // R1
  hit_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |-> seen_q);
  // R6
  lookahead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |-> run_q >= LOOK_C);
  // R6
  hit_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |=> !pred_hit);
  // R7
  redirect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !pred_hit);
  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |-> !pred_hit);
endmodule

bind brtgt_cache brtgt_cache_chk #(.LOOK(LOOK)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_vld (fetch_vld),
  .redirect  (redirect),
  .upd_vld   (upd_vld),
  .upd_taken (upd_taken),
  .pred_hit  (pred_hit)
);

// File: tb/brtgt_cache_tb.sv
module brtgt_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        redirect = 1'b0;
  logic        upd_vld = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_tgt = '0;
  logic        upd_taken = 1'b0;
  logic        pred_hit;
  logic [31:0] pred_tgt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brtgt_cache dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .redirect(redirect), .upd_vld(upd_vld), .upd_pc(upd_pc), .upd_tgt(upd_tgt),
    .upd_taken(upd_taken), .pred_hit(pred_hit), .pred_tgt(pred_tgt)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        rd;
    logic        vd;
    logic [31:0] a;
    logic        eh;
    logic [31:0] et;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{4'd6, 1'b1, 1'b0, 32'h0,    1'b0, 32'h0},
    '{4'd2, 1'b0, 1'b1, 32'hF8,   1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'hFC,   1'b0, 32'h0},
    '{4'd2, 1'b0, 1'b1, 32'h100,  1'b1, 32'h800},
    '{4'd6, 1'b0, 1'b1, 32'h800,  1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'h804,  1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'h808,  1'b0, 32'h0},
    '{4'd6, 1'b1, 1'b0, 32'h0,    1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'h7FC,  1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'h800,  1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'h804,  1'b1, 32'h900},
    '{4'd6, 1'b1, 1'b0, 32'h0,    1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'hFC,   1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'h100,  1'b0, 32'h0},
    '{4'd6, 1'b0, 1'b1, 32'h104,  1'b0, 32'h0},
    '{4'd5, 1'b1, 1'b0, 32'h0,    1'b0, 32'h0},
    '{4'd5, 1'b0, 1'b1, 32'h1F8,  1'b0, 32'h0},
    '{4'd5, 1'b0, 1'b1, 32'h1FC,  1'b0, 32'h0},
    '{4'd5, 1'b0, 1'b1, 32'h200,  1'b0, 32'h0},
    '{4'd2, 1'b1, 1'b0, 32'h0,    1'b0, 32'h0},
    '{4'd2, 1'b0, 1'b1, 32'h11F8, 1'b0, 32'h0},
    '{4'd2, 1'b0, 1'b1, 32'h11FC, 1'b0, 32'h0},
    '{4'd2, 1'b0, 1'b1, 32'h1200, 1'b1, 32'h3000},
    '{4'd3, 1'b1, 1'b0, 32'h0,    1'b0, 32'h0},
    '{4'd3, 1'b0, 1'b1, 32'h2F8,  1'b0, 32'h0},
    '{4'd3, 1'b0, 1'b1, 32'h2FC,  1'b0, 32'h0},
    '{4'd3, 1'b0, 1'b1, 32'h300,  1'b0, 32'h0},
    '{4'd8, 1'b1, 1'b0, 32'h0,    1'b0, 32'h0},
    '{4'd8, 1'b0, 1'b1, 32'h404,  1'b0, 32'h0},
    '{4'd8, 1'b0, 1'b1, 32'h408,  1'b0, 32'h0},
    '{4'd8, 1'b0, 1'b0, 32'h40C,  1'b0, 32'h0},
    '{4'd10,1'b0, 1'b1, 32'h40C,  1'b1, 32'h2000},
    '{4'd7, 1'b1, 1'b0, 32'h0,    1'b0, 32'h0},
    '{4'd7, 1'b0, 1'b1, 32'hF8,   1'b0, 32'h0},
    '{4'd7, 1'b0, 1'b1, 32'hFC,   1'b0, 32'h0},
    '{4'd7, 1'b1, 1'b1, 32'h100,  1'b0, 32'h0},
    '{4'd7, 1'b0, 1'b1, 32'h104,  1'b0, 32'h0}
  };

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  // inputs change at the falling edge; outputs are read 1 time unit later
  task automatic step(input logic rd, input logic vd, input logic [31:0] a,
                      input logic uv, input logic [31:0] pc,
                      input logic [31:0] tg, input logic tk);
    @(negedge clk);
    redirect = rd; fetch_vld = vd; fetch_addr = a;
    upd_vld = uv; upd_pc = pc; upd_tgt = tg; upd_taken = tk;
    #1;
  endtask

  task automatic fetch(input logic rd, input logic vd, input logic [31:0] a);
    step(rd, vd, a, 1'b0, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic update(input logic [31:0] pc, input logic [31:0] tg, input logic tk);
    step(1'b0, 1'b0, 32'h0, 1'b1, pc, tg, tk);
  endtask

  task automatic chk(input string req, input logic eh, input logic [31:0] et);
    checks++;
    if (pred_hit !== eh || pred_tgt !== et) begin
      errors++;
      $display("FAIL %s addr=%h hit=%0b exp %0b tgt=%h exp %h",
               req, fetch_addr, pred_hit, eh, pred_tgt, et);
    end
  endtask

  // restart, two lead-in fetches, then a checked third fetch
  task automatic run3(input string req, input logic [31:0] a,
                      input logic eh, input logic [31:0] et);
    fetch(1'b1, 1'b0, 32'h0);
    fetch(1'b0, 1'b1, a - 32'h8);
    fetch(1'b0, 1'b1, a - 32'h4);
    fetch(1'b0, 1'b1, a);
    chk(req, eh, et);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    fetch(1'b0, 1'b1, 32'h0);
    chk("R1", 1'b0, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    run3("R1", 32'h100, 1'b0, 32'h0);

    // R10: back-to-back packets, every one written
    update(32'h100,  32'h800,  1'b1);
    update(32'h804,  32'h900,  1'b1);
    update(32'h1200, 32'h3000, 1'b1);
    update(32'h300,  32'h3300, 1'b1);
    update(32'h300,  32'h3300, 1'b0);
    update(32'h40C,  32'h2000, 1'b1);
    fetch(1'b0, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      fetch(VECS[i].rd, VECS[i].vd, VECS[i].a);
      chk(rname(VECS[i].tag), VECS[i].eh, VECS[i].et);
    end

    // R4: an aliasing address replaces the old entry
    update(32'h2100, 32'h4000, 1'b1);
    run3("R4", 32'h100, 1'b0, 32'h0);
    run3("R4", 32'h2100, 1'b1, 32'h4000);

    // R9: write and lookahead read to index of 0x600 in one cycle
    fetch(1'b1, 1'b0, 32'h0);
    step(1'b0, 1'b1, 32'h5F8, 1'b1, 32'h600, 32'h6600, 1'b1);
    fetch(1'b0, 1'b1, 32'h5FC);
    fetch(1'b0, 1'b1, 32'h600);
    chk("R9", 1'b0, 32'h0);
    run3("R9", 32'h600, 1'b1, 32'h6600);

    // R11: no hit leaves the target at zero
    fetch(1'b0, 1'b1, 32'h604);
    chk("R11", 1'b0, 32'h0);

    // R1: reset mid-run clears the table
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    run3("R1", 32'h100, 1'b0, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule